// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block sits beside the data register of a NAND flash bridge and builds single-error-correcting Hamming parity over one 512-byte page while the page streams across a 16-bit data bus. The page is handled as two independent 256-byte halves. Each half yields a 16-bit line-parity word, which is two parity bits for every bit of the byte index, and a column-parity byte, which is two parity bits for every bit of the bit position within a byte. Every parity bit is stored inverted, so an erased page of all 0xFF gives an all-0xFF code.

Software drives the engine through byte writes to the bridge's mode register. One value clears the engine. The clear mode ignores data transfers, so the dummy data read that software issues after the clear has no effect. A second value starts accumulation over the following data transfers. A third value switches the data register to result readout, where three 16-bit reads return the six ECC bytes in a fixed interleaved order. The data-mode value, or any other mode value, stops accumulation and keeps the result. Correcting errors is left to software.

Top module: `ecc_page_gen`

## Requirements
- R1: After `rst`, the parity state is zero and the byte count is 0. A readout at that point returns 0xFFFF on all three reads.
- R2: A mode write of 0xF4 clears the parity and the byte count. Transfers made while the engine stays in this clear mode (the dummy read) change nothing.
- R3: In mode 0xB4 each `xfer_vld` cycle feeds two page bytes: `xfer_data[7:0]` at byte index n and `xfer_data[15:8]` at index n+1. The count then advances by 2.
- R4: Line parity of a half: for each index bit k (0..7), LP bit 2k+1 is the XOR of all data bits in the bytes whose index within the half has bit k = 1. LP bit 2k covers the bytes whose index has bit k = 0.
- R5: Column parity of a half: for each position bit k (0..2), CP bit 2k+1 is the XOR of the data bits at bit positions b with bit k of b = 1, taken over all 256 bytes. CP bit 2k covers the positions with bit k of b = 0. The CP byte is {CP5..CP0, 2'b11}.
- R6: Every LP and CP bit is returned inverted, so a page of all 0xFF (or all 0x00) gives six 0xFF bytes.
- R7: Page bytes 0..255 go to half 0 and bytes 256..511 go to half 1.
- R8: After 512 bytes have been fed, further transfers in mode 0xB4 are ignored.
- R9: In mode 0xD4, reads return these words in order, each written as {high byte, low byte}. Read 0 = {h0 LP15..8, h0 LP7..0}. Read 1 = {h1 LP7..0, h0 CP byte}. Read 2 = {h1 CP byte, h1 LP15..8}. A fourth read wraps to read 0.
- R10: `rd_vld` pulses with `rd_data` one cycle after an `rd_req` made in readout mode. An `rd_req` made in any other mode gives no `rd_vld`.
- R11: A mode write of 0x94, or of any value other than 0xF4, 0xB4 or 0xD4, stops accumulation and keeps the parity and the count. Transfers in that mode are ignored, and a later 0xB4 resumes at the kept count.
- R12: Each write of 0xD4 restarts readout at read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value written |
| xfer_vld | input | 1 | A data-register transfer occurs this cycle |
| xfer_data | input | BUS_W | Transferred bytes, lower byte first in page order |
| rd_req | input | 1 | Data-register read request |
| rd_vld | output | 1 | Result word valid |
| rd_data | output | 16 | ECC result word |

## Verification
The checker takes for granted that `mode_we` and `xfer_vld` or `rd_req` are never raised in the same cycle. It also takes for granted that `rd_req` is low during reset. The bench keeps to this because every mode write, transfer and read request is issued by its own task, each driving one strobe a step after a rising edge. Expected codes come from the parity definitions applied to a byte array held in the bench. The pages used are single-bit pages that move across both halves, all bit positions and all index bits, along with uniform, counting and random pages.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int HALF_ADDR_W = 8;
  localparam int LP_W        = 2 * HALF_ADDR_W;
  localparam int BIT_SEL_W   = 3;
  localparam int CP_W        = 2 * BIT_SEL_W;
  localparam int RES_W       = 16;
  localparam int RES_WORDS   = 3;

  localparam logic [7:0] CMD_CLEAR = 8'hF4;
  localparam logic [7:0] CMD_ACC   = 8'hB4;
  localparam logic [7:0] CMD_READ  = 8'hD4;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_CLEAR = 2'd1,
    ENG_ACC   = 2'd2,
    ENG_READ  = 2'd3
  } eng_state_t;

  // line-parity contribution of one byte with parity p at index a
  function automatic logic [LP_W-1:0] lp_term(input logic [HALF_ADDR_W-1:0] a,
                                              input logic p);
    logic [LP_W-1:0] r;
    for (int k = 0; k < HALF_ADDR_W; k++) begin
      r[2*k+1] = p & a[k];
      r[2*k]   = p & ~a[k];
    end
    return r;
  endfunction

  // column-parity contribution of one byte
  function automatic logic [CP_W-1:0] cp_term(input logic [7:0] d);
    logic [CP_W-1:0] r;
    r = '0;
    for (int k = 0; k < BIT_SEL_W; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> k) & 1) == 1) r[2*k+1] = r[2*k+1] ^ d[b];
        else                     r[2*k]   = r[2*k]   ^ d[b];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_cmd_decode.sv
module ecc_cmd_decode
  import ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_we,
  input  logic [7:0] mode_val,
  output eng_state_t eng_state,
  output logic       clear_cmd,
  output logic       read_cmd
);
  assign clear_cmd = mode_we && (mode_val == CMD_CLEAR);
  assign read_cmd  = mode_we && (mode_val == CMD_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_state <= ENG_IDLE;
    end else if (mode_we) begin
      case (mode_val)
        CMD_CLEAR: eng_state <= ENG_CLEAR;
        CMD_ACC:   eng_state <= ENG_ACC;
        CMD_READ:  eng_state <= ENG_READ;
        default:   eng_state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
  import ecc_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int PAGE_BYTES = 512,
  parameter int HALF_BYTES = 256,
  localparam int BUS_BYTES = BUS_W / 8,
  localparam int HALVES    = PAGE_BYTES / HALF_BYTES,
  localparam int HSEL_W    = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int CNT_W     = $clog2(PAGE_BYTES) + 1
)(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clear,
  input  logic                            acc_en,
  input  logic                            xfer_vld,
  input  logic [BUS_W-1:0]                xfer_data,
  output logic [HALVES-1:0][LP_W-1:0]     lp_acc,
  output logic [HALVES-1:0][CP_W-1:0]     cp_acc,
  output logic [CNT_W-1:0]                byte_cnt
);
  logic [BUS_BYTES-1:0][LP_W-1:0] lp_c;
  logic [BUS_BYTES-1:0][CP_W-1:0] cp_c;
  logic [BUS_BYTES-1:0][HSEL_W-1:0] half_c;
  logic [HALVES-1:0][LP_W-1:0] lp_nxt;
  logic [HALVES-1:0][CP_W-1:0] cp_nxt;
  logic take;

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    logic [7:0]       lane_byte;
    logic [CNT_W-1:0] lane_idx;
    assign lane_byte = xfer_data[8*k +: 8];
    assign lane_idx  = byte_cnt + CNT_W'(k);
    assign lp_c[k]   = lp_term(lane_idx[HALF_ADDR_W-1:0], ^lane_byte);
    assign cp_c[k]   = cp_term(lane_byte);
    assign half_c[k] = lane_idx[HALF_ADDR_W +: HSEL_W];
  end

  always_comb begin
    lp_nxt = lp_acc;
    cp_nxt = cp_acc;
    for (int k = 0; k < BUS_BYTES; k++) begin
      for (int h = 0; h < HALVES; h++) begin
        if (int'(half_c[k]) == h) begin
          lp_nxt[h] = lp_nxt[h] ^ lp_c[k];
          cp_nxt[h] = cp_nxt[h] ^ cp_c[k];
        end
      end
    end
  end

  assign take = acc_en && xfer_vld && (byte_cnt < CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lp_acc   <= '0;
      cp_acc   <= '0;
      byte_cnt <= '0;
    end else if (take) begin
      lp_acc   <= lp_nxt;
      cp_acc   <= cp_nxt;
      byte_cnt <= byte_cnt + CNT_W'(BUS_BYTES);
    end
  end
endmodule

// File: rtl/ecc_result_serial.sv
module ecc_result_serial
  import ecc_pkg::*;
#(
  parameter int HALVES = 2
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restart,
  input  logic                        rd_en,
  input  logic [HALVES-1:0][LP_W-1:0] lp_acc,
  input  logic [HALVES-1:0][CP_W-1:0] cp_acc,
  output logic [1:0]                  rd_ptr,
  output logic                        rd_vld,
  output logic [RES_W-1:0]            rd_data
);
  logic [7:0] cp0_byte, cp1_byte;
  logic [LP_W-1:0] lp0_inv, lp1_inv;
  logic [RES_W-1:0] word_sel;

  assign lp0_inv  = ~lp_acc[0];
  assign lp1_inv  = ~lp_acc[1];
  assign cp0_byte = {~cp_acc[0], 2'b11};
  assign cp1_byte = {~cp_acc[1], 2'b11};

  always_comb begin
    case (rd_ptr)
      2'd0:    word_sel = {lp0_inv[15:8], lp0_inv[7:0]};
      2'd1:    word_sel = {lp1_inv[7:0], cp0_byte};
      default: word_sel = {cp1_byte, lp1_inv[15:8]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (restart) begin
        rd_ptr <= '0;
      end else if (rd_en) begin
        rd_data <= word_sel;
        rd_ptr  <= (rd_ptr == 2'(RES_WORDS - 1)) ? 2'd0 : rd_ptr + 2'd1;
      end
    end
  end
endmodule

// File: rtl/ecc_page_gen.sv
module ecc_page_gen
  import ecc_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int PAGE_BYTES = 512,
  parameter int HALF_BYTES = 256,
  localparam int BUS_BYTES = BUS_W / 8,
  localparam int HALVES    = PAGE_BYTES / HALF_BYTES,
  localparam int CNT_W     = $clog2(PAGE_BYTES) + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [7:0]       mode_val,
  input  logic             xfer_vld,
  input  logic [BUS_W-1:0] xfer_data,
  input  logic             rd_req,
  output logic             rd_vld,
  output logic [15:0]      rd_data
);
  eng_state_t eng_state;
  logic clear_cmd, read_cmd;
  logic [HALVES-1:0][LP_W-1:0] lp_acc;
  logic [HALVES-1:0][CP_W-1:0] cp_acc;
  logic [CNT_W-1:0] byte_cnt;
  logic [1:0] rd_ptr;

  ecc_cmd_decode u_dec (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_val(mode_val),
    .eng_state(eng_state), .clear_cmd(clear_cmd), .read_cmd(read_cmd)
  );

  ecc_parity_accum #(.BUS_W(BUS_W), .PAGE_BYTES(PAGE_BYTES), .HALF_BYTES(HALF_BYTES)) u_acc (
    .clk(clk), .rst(rst), .clear(clear_cmd),
    .acc_en(eng_state == ENG_ACC && !mode_we),
    .xfer_vld(xfer_vld), .xfer_data(xfer_data),
    .lp_acc(lp_acc), .cp_acc(cp_acc), .byte_cnt(byte_cnt)
  );

  ecc_result_serial #(.HALVES(HALVES)) u_ser (
    .clk(clk), .rst(rst), .restart(read_cmd),
    .rd_en(eng_state == ENG_READ && rd_req && !mode_we),
    .lp_acc(lp_acc), .cp_acc(cp_acc),
    .rd_ptr(rd_ptr), .rd_vld(rd_vld), .rd_data(rd_data)
  );
endmodule

// File: rtl/ecc_page_gen_chk.sv
module ecc_page_gen_chk
  import ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int BUS_BYTES  = 2,
  parameter int HALVES     = 2,
  localparam int CNT_W     = $clog2(PAGE_BYTES) + 1
)(
  input logic                        clk,
  input logic                        rst,
  input logic                        mode_we,
  input logic [7:0]                  mode_val,
  input logic                        xfer_vld,
  input logic                        rd_req,
  input logic                        rd_vld,
  input eng_state_t                  eng_state,
  input logic [CNT_W-1:0]            byte_cnt,
  input logic [1:0]                  rd_ptr,
  input logic [HALVES-1:0][LP_W-1:0] lp_acc
);
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CNT_W'(PAGE_BYTES));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_val == CMD_CLEAR) |=> (byte_cnt == '0 && lp_acc == '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_we && eng_state == ENG_ACC && xfer_vld && byte_cnt < CNT_W'(PAGE_BYTES))
      |=> byte_cnt == $past(byte_cnt) + CNT_W'(BUS_BYTES));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_we && eng_state != ENG_ACC) |=> ($stable(byte_cnt) && $stable(lp_acc)));

  // R10
  vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($past(rd_req) && $past(eng_state) == ENG_READ));

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ptr < 2'd3);

  // R12
  ptr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_val == CMD_READ) |=> rd_ptr == 2'd0);
endmodule

bind ecc_page_gen ecc_page_gen_chk #(
  .PAGE_BYTES(PAGE_BYTES), .BUS_BYTES(BUS_BYTES), .HALVES(HALVES)
) u_chk (
  .clk(clk), .rst(rst), .mode_we(mode_we), .mode_val(mode_val),
  .xfer_vld(xfer_vld), .rd_req(rd_req), .rd_vld(rd_vld),
  .eng_state(eng_state), .byte_cnt(byte_cnt), .rd_ptr(rd_ptr), .lp_acc(lp_acc)
);

// File: tb/ecc_page_gen_test.sv
`timescale 1ns/1ps
module ecc_page_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we = 1'b0;
  logic [7:0] mode_val = '0;
  logic xfer_vld = 1'b0;
  logic [15:0] xfer_data = '0;
  logic rd_req = 1'b0;
  logic rd_vld;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] pg [512];
  logic [15:0] expw [3];

  always #2.5 clk = ~clk;

  ecc_page_gen uut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_val(mode_val),
    .xfer_vld(xfer_vld), .xfer_data(xfer_data), .rd_req(rd_req),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // expected code from the parity definitions (R4, R5, R6, R9)
  task automatic model();
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [7:0]  cb [2];
    for (int h = 0; h < 2; h++) begin
      lp[h] = '0; cp[h] = '0;
      for (int i = 0; i < 256; i++) begin
        logic [7:0] d;
        d = pg[h*256 + i];
        for (int b = 0; b < 8; b++) begin
          if (d[b]) begin
            for (int k = 0; k < 8; k++) begin
              if (((i >> k) & 1) == 1) lp[h][2*k+1] = ~lp[h][2*k+1];
              else                     lp[h][2*k]   = ~lp[h][2*k];
            end
            for (int k = 0; k < 3; k++) begin
              if (((b >> k) & 1) == 1) cp[h][2*k+1] = ~cp[h][2*k+1];
              else                     cp[h][2*k]   = ~cp[h][2*k];
            end
          end
        end
      end
      lp[h] = ~lp[h];
      cb[h] = {~cp[h], 2'b11};
    end
    expw[0] = lp[0];
    expw[1] = {lp[1][7:0], cb[0]};
    expw[2] = {cb[1], lp[1][15:8]};
  endtask

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mode_wr(input logic [7:0] v);
    @(posedge clk); #1;
    mode_we = 1'b1; mode_val = v;
    @(posedge clk); #1;
    mode_we = 1'b0;
  endtask

  task automatic send_one(input logic [15:0] w);
    @(posedge clk); #1;
    xfer_vld = 1'b1; xfer_data = w;
    @(posedge clk); #1;
    xfer_vld = 1'b0;
  endtask

  task automatic send_words(input int first, input int n);
    for (int j = first; j < first + n; j++) begin
      @(posedge clk); #1;
      xfer_vld = 1'b1;
      xfer_data = {pg[(2*j+1) % 512], pg[(2*j) % 512]};
    end
    @(posedge clk); #1;
    xfer_vld = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] d, output logic v);
    @(posedge clk); #1;
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
    v = rd_vld;
    d = rd_data;
  endtask

  task automatic read_check(input string req);
    logic [15:0] d;
    logic v;
    mode_wr(8'hD4);
    for (int r = 0; r < 3; r++) begin
      read_word(d, v);
      check16({req, " vld"}, {15'd0, v}, 16'd1);
      check16(req, d, expw[r]);
    end
  endtask

  // clear, dummy read, accumulate full page, read back
  task automatic run_page(input string req);
    mode_wr(8'hF4);
    send_one(16'h5AC3);            // dummy read in clear mode (R2)
    mode_wr(8'hB4);
    send_words(0, 256);
    model();
    read_check(req);
    mode_wr(8'h94);
  endtask

  initial begin
    logic [15:0] d;
    logic v;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state read out
    for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    model();
    read_check("R1");

    // R10 read request outside readout mode
    mode_wr(8'h94);
    read_word(d, v);
    check16("R10 no vld in data mode", {15'd0, v}, 16'd0);

    // R6 erased page and zero page
    for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
    run_page("R6 erased");
    for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    run_page("R6 zero");

    // R4 R5 R7 single-bit sweep across both halves, every bit and index bit
    for (int n = 0; n < 64; n++) begin
      for (int i = 0; i < 512; i++) pg[i] = 8'h00;
      pg[n*8 + (n % 7)] = 8'h01 << (n % 8);
      run_page("R4 R5 R7 single bit");
    end

    // R3 counting bytes exercise lane order
    for (int i = 0; i < 512; i++) pg[i] = 8'(i * 7 + 3);
    run_page("R3 counting");

    // R7 only half 1 populated
    for (int i = 0; i < 512; i++) pg[i] = (i >= 256) ? 8'(i ^ 8'h5C) : 8'h00;
    run_page("R7 half1 only");

    // random pages
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
      run_page("R4 R5 random");
    end

    // R8 transfers past 512 bytes ignored
    for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
    mode_wr(8'hF4);
    mode_wr(8'hB4);
    send_words(0, 256);
    for (int j = 0; j < 40; j++) send_one(16'(j * 16'h1357 + 1));
    model();
    read_check("R8 overflow");

    // R11 mode change mid-page keeps state, transfers ignored, resume
    for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
    mode_wr(8'hF4);
    mode_wr(8'hB4);
    send_words(0, 100);
    mode_wr(8'h94);
    for (int j = 0; j < 6; j++) send_one(16'hBEEF + 16'(j));
    mode_wr(8'h0C);
    send_one(16'h1234);
    mode_wr(8'hB4);
    send_words(100, 156);
    model();
    read_check("R11 pause resume");

    // R9 wrap after third read, R12 restart on new readout command
    read_word(d, v);
    check16("R9 wrap", d, expw[0]);
    read_word(d, v);
    check16("R9 second after wrap", d, expw[1]);
    mode_wr(8'hD4);
    read_word(d, v);
    check16("R12 restart", d, expw[0]);

    // R2 clear without data gives erased code
    mode_wr(8'hF4);
    send_one(16'h0001);
    for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    model();
    read_check("R2 clear");

    // R10 request in clear mode gives nothing
    mode_wr(8'hF4);
    read_word(d, v);
    check16("R10 no vld in clear mode", {15'd0, v}, 16'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule